// File: doc/BRIEF.md
# Single-Word Write Target for a Shared Parallel Bus

This block is the responding side of a 32-bit synchronous bus that shares one address/data path. It handles write cycles only. When an initiator pulls the frame line low with an address and a command, the block checks whether the command is an I/O write or a memory write. It then compares the top address bits with the matching base value. On a hit it claims the cycle after a fixed slow decode, takes in exactly one 32-bit data word, and hands that word to the local side with the captured address.

The bus's active-low control lines are modelled as a drive value and an output-enable pair, so the shared-line turnaround is visible at the ports. Each control line the block owns is pulled low while active. It is then driven high for one cycle and released. If the initiator still holds frame low when its ready is accepted, it is attempting a burst. The block still accepts the first word, but it raises a disconnect on the stop line and holds it until frame is released.

Top module: `wtgt_write_target`

## Requirements
- R1: Only command code 4'b0011 (I/O write, `ad[31:8]` compared with `io_base`) and 4'b0111 (memory write, `ad[31:8]` compared with `mem_base`), sampled on the clock edge where frame first goes low, are claimed. Any other code or a mismatch leaves every output enable low and produces no write strobe.
- R2: On a hit sampled at edge k, the device-select line is driven low (`devsel_oe`=1, `devsel_o`=0) from edge k+2 onward, and it is not enabled before that.
- R3: Initiator ready is first considered at edge k+4. At the first edge from then on where `irdy_n` is low, the target-ready line is driven low for exactly one cycle.
- R4: The data word is captured on the edge after target-ready was driven. From that edge `wr_valid` is high for exactly one cycle, with `wr_addr` holding the full 32-bit address-phase value and `wr_data` the captured word. Byte enables in the data phase are ignored.
- R5: In a single-word cycle (frame high when ready is accepted), device select is deasserted together with target-ready.
- R6: If frame is still low when ready is accepted, stop is driven low in the same cycle as target-ready. Stop and device select stay low until frame is sampled high.
- R7: Each of device select, target-ready and stop is driven high for exactly one cycle after its low period and then left undriven (enable low).
- R8: After a transaction, whether claimed or ignored, nothing is decoded again until `frame_n` and `irdy_n` are both sampled high. A matching address and command that appear on the bus while frame stays low are not claimed.
- R9: A low `rst_n` sampled at a clock edge turns off all output enables and `wr_valid` from that edge. The block then waits for an idle bus before it decodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Initiator frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | 32 | Address/data path |
| cbe_n | input | 4 | Command in the address phase, byte enables afterwards |
| io_base | input | 24 | Upper address bits claimed for I/O writes |
| mem_base | input | 24 | Upper address bits claimed for memory writes |
| devsel_o | output | 1 | Device-select drive value |
| devsel_oe | output | 1 | Device-select output enable |
| trdy_o | output | 1 | Target-ready drive value |
| trdy_oe | output | 1 | Target-ready output enable |
| stop_o | output | 1 | Stop drive value |
| stop_oe | output | 1 | Stop output enable |
| wr_valid | output | 1 | One-cycle write strobe to the local side |
| wr_addr | output | 32 | Address of the captured write |
| wr_data | output | 32 | Captured data word |

## Verification
Counting from the address edge k, device select is due after edge k+2. Target-ready is due after edge k+4, or after the first later edge on which initiator ready is seen low. The strobe and the high release of target-ready follow one edge later. Stop and device select release one edge after frame is sampled high. The bench drives on falling edges and indexes every falling edge after k. It works out each due index from the ready delay and the frame hold it applied, and checks each output only at that index. The write monitor pops the expected address and data from a queue on every strobe, so both a missing strobe and an extra one are reported.

// File: rtl/wtgt_pkg.sv
package wtgt_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_IDLE,
    ST_IDLE,
    ST_DEC1,
    ST_DEC2,
    ST_CLAIM,
    ST_WAIT_IRDY,
    ST_XFER,
    ST_HOLD_STOP
  } wtgt_state_e;

  localparam logic [3:0] CMD_IO_WRITE  = 4'b0011;
  localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

  // Selects which base a command is compared with: 2'b01 io, 2'b10 mem, 0 none.
  function automatic logic [1:0] cmd_space(input logic [3:0] cmd);
    case (cmd)
      CMD_IO_WRITE:  cmd_space = 2'b01;
      CMD_MEM_WRITE: cmd_space = 2'b10;
      default:       cmd_space = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/wtgt_decode.sv
module wtgt_decode
  import wtgt_pkg::*;
#(
  parameter int BASE_W = 24
) (
  input  logic [3:0]        cmd,
  input  logic [BASE_W-1:0] upper,
  input  logic [BASE_W-1:0] io_base,
  input  logic [BASE_W-1:0] mem_base,
  output logic              hit
);
  logic [1:0] space;

  always_comb begin
    space = cmd_space(cmd);
    hit   = (space[0] && (upper == io_base)) || (space[1] && (upper == mem_base));
  end
endmodule

// File: rtl/wtgt_pin.sv
module wtgt_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  output logic drv_o,
  output logic oe_o
);
  logic rel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= act_i;
  end

  // Low while active, high for the single cycle after, then undriven.
  assign drv_o = !act_i;
  assign oe_o  = act_i || rel_q;
endmodule

// File: rtl/wtgt_write_target.sv
module wtgt_write_target
  import wtgt_pkg::*;
#(
  parameter int DW     = 32,
  parameter int BASE_W = 24,
  parameter int CBE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [DW-1:0]     ad,
  input  logic [CBE_W-1:0]  cbe_n,
  input  logic [BASE_W-1:0] io_base,
  input  logic [BASE_W-1:0] mem_base,
  output logic              devsel_o,
  output logic              devsel_oe,
  output logic              trdy_o,
  output logic              trdy_oe,
  output logic              stop_o,
  output logic              stop_oe,
  output logic              wr_valid,
  output logic [DW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data
);
  localparam int LOW_W  = DW - BASE_W;
  localparam int N_PINS = 3;
  localparam int P_DEV  = 0;
  localparam int P_TRDY = 1;
  localparam int P_STOP = 2;

  wtgt_state_e state_q, state_d;
  logic        burst_q;
  logic        addr_hit;

  // Named events for the checker.
  logic start_evt, claim_evt, miss_evt, accept_evt;
  logic devsel_act, trdy_act, stop_act;

  logic [N_PINS-1:0] pin_act, pin_drv, pin_oe;

  wtgt_decode #(.BASE_W(BASE_W)) u_dec (
    .cmd      (cbe_n[3:0]),
    .upper    (ad[DW-1:LOW_W]),
    .io_base  (io_base),
    .mem_base (mem_base),
    .hit      (addr_hit)
  );

  assign start_evt  = (state_q == ST_IDLE) && !frame_n;
  assign claim_evt  = start_evt && addr_hit;
  assign miss_evt   = start_evt && !addr_hit;
  assign accept_evt = (state_q == ST_WAIT_IRDY) && !irdy_n;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_WAIT_IDLE: if (frame_n && irdy_n) state_d = ST_IDLE;
      ST_IDLE:      if (!frame_n) state_d = addr_hit ? ST_DEC1 : ST_WAIT_IDLE;
      ST_DEC1:      state_d = ST_DEC2;
      ST_DEC2:      state_d = ST_CLAIM;
      ST_CLAIM:     state_d = ST_WAIT_IRDY;
      ST_WAIT_IRDY: if (!irdy_n) state_d = ST_XFER;
      ST_XFER:      state_d = burst_q ? ST_HOLD_STOP : ST_WAIT_IDLE;
      ST_HOLD_STOP: if (frame_n) state_d = ST_WAIT_IDLE;
      default:      state_d = ST_WAIT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_WAIT_IDLE;
      burst_q  <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      state_q  <= state_d;
      wr_valid <= (state_q == ST_XFER);
      if (start_evt) wr_addr <= ad;
      if (accept_evt) burst_q <= !frame_n;
      if (state_q == ST_XFER) wr_data <= ad;
    end
  end

  assign devsel_act = (state_q == ST_CLAIM) || (state_q == ST_WAIT_IRDY) ||
                      (state_q == ST_XFER)  || (state_q == ST_HOLD_STOP);
  assign trdy_act   = (state_q == ST_XFER);
  assign stop_act   = ((state_q == ST_XFER) && burst_q) || (state_q == ST_HOLD_STOP);

  assign pin_act[P_DEV]  = devsel_act;
  assign pin_act[P_TRDY] = trdy_act;
  assign pin_act[P_STOP] = stop_act;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    wtgt_pin u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .act_i (pin_act[i]),
      .drv_o (pin_drv[i]),
      .oe_o  (pin_oe[i])
    );
  end

  assign devsel_o  = pin_drv[P_DEV];
  assign devsel_oe = pin_oe[P_DEV];
  assign trdy_o    = pin_drv[P_TRDY];
  assign trdy_oe   = pin_oe[P_TRDY];
  assign stop_o    = pin_drv[P_STOP];
  assign stop_oe   = pin_oe[P_STOP];
endmodule

// File: rtl/wtgt_write_target_chk.sv
module wtgt_write_target_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_n,
  input logic irdy_n,
  input logic devsel_o,
  input logic devsel_oe,
  input logic trdy_o,
  input logic trdy_oe,
  input logic stop_o,
  input logic stop_oe,
  input logic wr_valid,
  input logic claim_evt,
  input logic miss_evt
);
  logic dev_low, trdy_low, stop_low;
  assign dev_low  = devsel_oe && !devsel_o;
  assign trdy_low = trdy_oe && !trdy_o;
  assign stop_low = stop_oe && !stop_o;

  // R2
  claim_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim_evt |-> ##3 dev_low);

  // R1
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |-> ##3 (!devsel_oe && !trdy_oe && !stop_oe));

  // R3
  trdy_after_irdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trdy_low |-> (dev_low && $past(!irdy_n)));

  // R4
  strobe_after_trdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(trdy_low));

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_low && !frame_n) |=> stop_low);

  // R6
  stop_with_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_low |-> dev_low);

  // R7
  trdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trdy_low |=> (trdy_oe && trdy_o) ##1 !trdy_oe);

  // R7
  devsel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dev_low) && $past(rst_n)) |-> (devsel_oe && devsel_o));

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stop_low) && $past(rst_n)) |-> (stop_oe && stop_o));

  // R9
  reset_float_chk: assert property (@(posedge clk)
    !rst_n |=> (!devsel_oe && !trdy_oe && !stop_oe && !wr_valid));
endmodule

bind wtgt_write_target wtgt_write_target_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_n   (frame_n),
  .irdy_n    (irdy_n),
  .devsel_o  (devsel_o),
  .devsel_oe (devsel_oe),
  .trdy_o    (trdy_o),
  .trdy_oe   (trdy_oe),
  .stop_o    (stop_o),
  .stop_oe   (stop_oe),
  .wr_valid  (wr_valid),
  .claim_evt (claim_evt),
  .miss_evt  (miss_evt)
);

// File: tb/wtgt_write_target_test.sv
`timescale 1ns/1ps
module wtgt_write_target_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic [23:0] io_base = 24'h00C0DE;
  logic [23:0] mem_base = 24'hFEED01;
  logic        devsel_o, devsel_oe, trdy_o, trdy_oe, stop_o, stop_oe;
  logic        wr_valid;
  logic [31:0] wr_addr, wr_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [63:0] exp_q[$];

  always #2.5 clk = ~clk;

  wtgt_write_target uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad(ad), .cbe_n(cbe_n), .io_base(io_base), .mem_base(mem_base),
    .devsel_o(devsel_o), .devsel_oe(devsel_oe), .trdy_o(trdy_o), .trdy_oe(trdy_oe),
    .stop_o(stop_o), .stop_oe(stop_oe), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Pin state codes: 0 undriven, 1 driven low, 2 driven high.
  function automatic int pin(input logic v, input logic oe);
    return !oe ? 0 : (v ? 2 : 1);
  endfunction

  // Monitor: every strobe pops one expected {addr, data}.
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) check(0, "R4 unexpected strobe", {wr_addr, wr_data}, 64'h0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        check({wr_addr, wr_data} == e, "R4 strobe contents", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic bus_idle();
    frame_n = 1'b1; irdy_n = 1'b1; ad = '0; cbe_n = 4'hF;
  endtask

  // d: index at which ready is driven low; h: extra frame hold after stop.
  task automatic run_wr(input logic [31:0] addr, input logic [3:0] cmd, input logic [31:0] data,
                        input logic [3:0] be, input bit claim, input bit burst, input int d, input int h);
    int tx;
    int last;
    tx = (d + 1 > 4) ? d + 1 : 4;
    last = burst ? tx + 4 + h : tx + 4;
    if (claim) exp_q.push_back({addr, data});
    @(negedge clk);
    frame_n = 1'b0; ad = addr; cbe_n = cmd;
    for (int c = 0; c <= last; c++) begin
      @(negedge clk);
      if (!claim) begin
        if (c <= 6) check(!devsel_oe && !trdy_oe && !stop_oe, "R1 ignored cycle quiet",
                          {devsel_oe, trdy_oe, stop_oe}, 0);
      end else begin
        if (c == 1) check(!devsel_oe, "R2 no early devsel", devsel_oe, 0);
        if (c == 2) check(pin(devsel_o, devsel_oe) == 1, "R2 devsel low", pin(devsel_o, devsel_oe), 1);
        if (c == tx - 1) check(!trdy_oe, "R3 no early trdy", trdy_oe, 0);
        if (c == tx) begin
          check(pin(trdy_o, trdy_oe) == 1, "R3 trdy low", pin(trdy_o, trdy_oe), 1);
          check(pin(stop_o, stop_oe) == (burst ? 1 : 0), "R6 stop with trdy",
                pin(stop_o, stop_oe), burst ? 1 : 0);
        end
        if (c == tx + 1) begin
          check(wr_valid, "R4 strobe due", wr_valid, 1);
          check(pin(trdy_o, trdy_oe) == 2, "R7 trdy release high", pin(trdy_o, trdy_oe), 2);
        end
        if (c == tx + 2) begin
          check(!trdy_oe, "R7 trdy undriven", trdy_oe, 0);
          check(!wr_valid, "R4 strobe one cycle", wr_valid, 0);
        end
        if (!burst) begin
          if (c == tx + 1) check(pin(devsel_o, devsel_oe) == 2, "R5 devsel released", pin(devsel_o, devsel_oe), 2);
          if (c == tx + 2) check(!devsel_oe, "R7 devsel undriven", devsel_oe, 0);
        end else begin
          if (c == tx + 1 + h) begin
            check(pin(stop_o, stop_oe) == 1, "R6 stop held", pin(stop_o, stop_oe), 1);
            check(pin(devsel_o, devsel_oe) == 1, "R6 devsel held", pin(devsel_o, devsel_oe), 1);
          end
          if (c == tx + 2 + h) check(pin(stop_o, stop_oe) == 2, "R7 stop release high", pin(stop_o, stop_oe), 2);
          if (c == tx + 3 + h) check(!stop_oe && !devsel_oe, "R7 stop undriven", {stop_oe, devsel_oe}, 0);
        end
      end
      // Initiator actions after sampling.
      if (c == 0) begin ad = data; cbe_n = be; end
      if (c == d) begin irdy_n = 1'b0; if (!burst) frame_n = 1'b1; end
      if (!burst && c == tx + 1) irdy_n = 1'b1;
      if (burst && c == tx + 1 + h) begin frame_n = 1'b1; irdy_n = 1'b1; end
    end
    bus_idle();
    @(negedge clk);
  endtask

  task automatic reset_mid();
    @(negedge clk);
    frame_n = 1'b0; ad = {mem_base, 8'h40}; cbe_n = 4'b0111;
    for (int c = 0; c <= 2; c++) @(negedge clk);
    check(pin(devsel_o, devsel_oe) == 1, "R2 devsel before reset", pin(devsel_o, devsel_oe), 1);
    rst_n = 1'b0;
    ad = {mem_base, 8'h44};
    @(negedge clk);
    check(!devsel_oe && !trdy_oe && !stop_oe && !wr_valid, "R9 reset floats outputs",
          {devsel_oe, trdy_oe, stop_oe, wr_valid}, 0);
    rst_n = 1'b1;
    // Frame held low with a matching address: must not be claimed.
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(!devsel_oe, "R9 waits for idle after reset", devsel_oe, 0);
    end
    bus_idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!devsel_oe && !trdy_oe && !stop_oe && !wr_valid, "R9 reset state",
          {devsel_oe, trdy_oe, stop_oe, wr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_wr({mem_base, 8'h10}, 4'b0111, 32'h1234_5678, 4'h0, 1, 0, 0, 0);
    run_wr({io_base, 8'hFC},  4'b0011, 32'hCAFE_0001, 4'hA, 1, 0, 5, 0);
    run_wr({mem_base, 8'h00}, 4'b0111, 32'hDEAD_BEEF, 4'h0, 1, 1, 0, 0);
    run_wr({mem_base, 8'h20}, 4'b0111, 32'h0BAD_F00D, 4'h3, 1, 1, 2, 3);
    // R8: data phase repeats a matching address and command while frame is low.
    run_wr({mem_base, 8'h30}, 4'b0011, {mem_base, 8'h30}, 4'b0111, 0, 0, 3, 0);
    run_wr({mem_base, 8'h30}, 4'b0110, {mem_base, 8'h34}, 4'b0111, 0, 0, 0, 0);
    run_wr({mem_base ^ 24'h000100, 8'h30}, 4'b0111, 32'h5555_AAAA, 4'h0, 0, 0, 0, 0);
    run_wr({io_base, 8'h00}, 4'b0111, 32'h7777_0000, 4'h0, 0, 0, 0, 0);
    reset_mid();
    run_wr({io_base, 8'h08}, 4'b0011, 32'hA5A5_5A5A, 4'hF, 1, 0, 1, 0);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule